// File: doc/BRIEF.md
# Power-of-Two Delay Timer

This block measures out a programmable wait for supply sequencing logic. The control logic raises `start`. The timer then counts ticks until it reaches a length picked by a 4-bit code, and it raises `done`. The lengths form a doubling ladder. Code n asks for 8·2^n ticks. On the internal time base of 250 kHz (one tick every 4 us), the ladder runs from 32 us at code 0 up to a ceiling of 512 ms.

The internal tick comes from dividing the system clock by `TICK_DIV`. When a much longer wait is needed, the timer can count a clock enable supplied from outside instead. Both the source choice and the length are captured when the count begins. Dropping `start` clears the timer, so one timer can serve several control conditions one after another, each arming it with its own length.

Top module: `pow2_delay_timer`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: Code n on `dur_sel` selects 8·2^n ticks. Codes 14 and 15 saturate at `MAX_TICKS` (128000 ticks, 512 ms at 4 us per tick). An internal tick lasts `TICK_DIV` clock cycles.
- R3: `busy` rises in the cycle after a rising edge of `start`. For a length of N ticks on the internal source, `done` rises exactly N·`TICK_DIV`+1 cycles after the clock edge that captured the rising `start`. `busy` falls in the same cycle.
- R4: `done` stays high for as long as `start` stays high. A clock edge that sees `start` low clears `done`, `busy` and the count.
- R5: Every rising edge of `start` reloads the length. If `start` is taken low for one cycle during a count and then raised with a new code, timing restarts from that edge using the new code.
- R6: When `src_ext` is 1 at the start, the count advances by one on each clock edge that sees `ext_tick` high. No other event advances it.
- R7: `src_ext` is captured only at the rising edge of `start`. Changing it during a count neither speeds up nor stalls the count.
- R8: `dur_sel` is captured only at the rising edge of `start`. Changing it during a count does not change when `done` rises.
- R9: `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm request; a rising edge starts a count, low clears |
| dur_sel | input | 4 | Ladder code for the delay length |
| src_ext | input | 1 | 1 selects the external tick, 0 the internal divider |
| ext_tick | input | 1 | External one-cycle count enable |
| busy | output | 1 | A count is in progress |
| done | output | 1 | The selected length has elapsed |

## Verification
The assertions assume that `start`, `src_ext`, `dur_sel` and `ext_tick` are synchronous to `clk` and that `start` is low while reset is held. Under those conditions the history used by `$past` and `$rose` is meaningful from the first edge after reset. The bench keeps to this by changing every input only on the falling clock edge. It holds `start` low through reset, and it produces external ticks as single-cycle enables rather than as a second clock.

// File: rtl/pow2_delay_timer.sv
module pow2_delay_timer #(
  parameter int TICK_DIV   = 500,
  parameter int SEL_W      = 4,
  parameter int BASE_TICKS = 8,
  parameter int MAX_TICKS  = 128000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] dur_sel,
  input  logic             src_ext,
  input  logic             ext_tick,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = $clog2(MAX_TICKS + 1);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic             start_q;
  logic             src_q;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] dur_len;
  logic             int_tick;
  logic             tick;
  logic             arm;
  logic             at_end;

  function automatic logic [CNT_W-1:0] ladder(input logic [SEL_W-1:0] code);
    logic [63:0] v;
    v = 64'(BASE_TICKS) << code;
    if (v > 64'(MAX_TICKS)) v = 64'(MAX_TICKS);
    return CNT_W'(v);
  endfunction

  assign dur_len  = ladder(dur_sel);
  assign arm      = start && !start_q;
  assign int_tick = (presc == PRE_LAST);
  assign tick     = src_q ? ext_tick : int_tick;
  assign at_end   = (cnt == tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      src_q   <= 1'b0;
      tgt     <= '0;
      cnt     <= '0;
      presc   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      start_q <= start;
      if (!start) begin
        cnt   <= '0;
        presc <= '0;
        busy  <= 1'b0;
        done  <= 1'b0;
      end else if (arm) begin
        tgt   <= dur_len;
        src_q <= src_ext;
        cnt   <= '0;
        presc <= '0;
        busy  <= 1'b1;
        done  <= 1'b0;
      end else if (busy) begin
        if (at_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          presc <= int_tick ? '0 : presc + 1'b1;
          if (tick) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> done); // R4

  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !busy && !done); // R4

  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |=> busy); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= tgt); // R2

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && start && $past(start) |-> $stable(src_q)); // R7

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && start && $past(start) |-> $stable(tgt)); // R8

endmodule

// File: tb/sim_pow2_delay_timer.sv
module sim_pow2_delay_timer;
  localparam int DIV = 2;
  localparam int NV  = 6;
  localparam logic [3:0] VEC_CODE  [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7};
  localparam int         VEC_TICKS [NV] = '{8, 16, 32, 64, 256, 1024};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] dur_sel = '0;
  logic src_ext = 1'b0;
  logic ext_tick = 1'b0;
  logic busy, done;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pow2_delay_timer #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dur_sel(dur_sel),
    .src_ext(src_ext), .ext_tick(ext_tick), .busy(busy), .done(done));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_int(input logic [3:0] code, input int n, input string req);
    @(negedge clk);
    dur_sel = code; src_ext = 1'b0; start = 1'b1;
    cycles(n * DIV + 1);
    chk(req, "busy before end", busy, 1'b1);
    chk(req, "done before end", done, 1'b0);
    cycles(1);
    chk(req, "done at end", done, 1'b1);
    chk(req, "busy at end", busy, 1'b0);
    cycles(3);
    chk("R4", "done held", done, 1'b1);
    start = 1'b0;
    cycles(1);
    chk("R4", "done cleared", done, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "done in reset", done, 1'b0);
    rst_n = 1'b1;
    cycles(2);
    chk("R1", "busy after reset", busy, 1'b0);

    for (int i = 0; i < NV; i++) run_int(VEC_CODE[i], VEC_TICKS[i], "R2 R3");

    // R3: busy the cycle after arming
    start = 1'b1; dur_sel = 4'd0;
    cycles(1);
    chk("R3", "busy after arm", busy, 1'b1);
    start = 1'b0;
    cycles(1);
    chk("R4", "busy cleared", busy, 1'b0);

    // R5: restart with new code
    dur_sel = 4'd3; start = 1'b1;
    cycles(20);
    start = 1'b0;
    cycles(1);
    chk("R5", "gap clears busy", busy, 1'b0);
    dur_sel = 4'd0; start = 1'b1;
    cycles(8 * DIV + 1);
    chk("R5", "new code not yet done", done, 1'b0);
    cycles(1);
    chk("R5", "new code done", done, 1'b1);
    start = 1'b0;
    cycles(1);

    // R8: duration change mid-count ignored
    dur_sel = 4'd1; start = 1'b1;
    cycles(4);
    dur_sel = 4'd0;
    cycles(16 * DIV + 1 - 4);
    chk("R8", "done not early", done, 1'b0);
    cycles(1);
    chk("R8", "done on original length", done, 1'b1);
    start = 1'b0;
    cycles(1);

    // R7: switch to external mid-count, no ticks, still finishes
    dur_sel = 4'd0; src_ext = 1'b0; start = 1'b1;
    cycles(5);
    src_ext = 1'b1; ext_tick = 1'b0;
    cycles(8 * DIV + 1 - 5);
    chk("R7", "internal not stalled busy", busy, 1'b1);
    cycles(1);
    chk("R7", "internal not stalled done", done, 1'b1);
    start = 1'b0;
    cycles(1);

    // R7/R6: external source, switch to internal ignored
    src_ext = 1'b1; dur_sel = 4'd0; start = 1'b1;
    cycles(3);
    src_ext = 1'b0;
    cycles(100);
    chk("R7", "external still waiting busy", busy, 1'b1);
    chk("R6", "no ticks no done", done, 1'b0);
    for (int p = 0; p < 8; p++) begin
      ext_tick = 1'b1;
      cycles(1);
      ext_tick = 1'b0;
      cycles(2);
      if (p == 6) chk("R6", "seven ticks not done", done, 1'b0);
    end
    chk("R6", "eight ticks done", done, 1'b1);
    start = 1'b0;
    cycles(1);

    // R2: saturation of code 15 via external tick every cycle
    src_ext = 1'b1; ext_tick = 1'b1; dur_sel = 4'd15; start = 1'b1;
    cycles(128000 + 1);
    chk("R2", "code15 not before cap", done, 1'b0);
    chk("R9", "busy alone", busy, 1'b1);
    cycles(1);
    chk("R2", "code15 done at cap", done, 1'b1);
    chk("R9", "busy low with done", busy, 1'b0);
    start = 1'b0; ext_tick = 1'b0;
    cycles(1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule